// File: doc/BRIEF.md
# Acknowledge Wait Sequencer

This block runs the tag reply phases that come after a write-type command has been sent over a low-frequency link. On a start strobe, it takes a command kind and three counts, all in bit periods: a first delay, a second delay and a search window. First it waits out the first delay. Then it arms an external acknowledge matcher for at most the search window. If an acknowledge is found, it waits out the second delay. A data write then gets a second bounded acknowledge search. A PIN-style command instead gets a one-cycle arm pulse to the header detector that will capture the returned identifier.

A rejected check ends the sequence at once with a fail status. A search that finds nothing before its window runs out ends with a timeout, so a missing tag can never hold the sequencer. When the block is done, the tag is back in its listen window. The result stays on the outputs until the next start. Counting advances only on a bit-period strobe, so the block can run from any system clock.

Top module: `ack_wait_seq`

## Requirements
- R1: Out of reset the block is idle: `busy`, `done`, `ack_arm` and `hdr_arm` are low and `status` is 0.
- R2: After a start, the block stays busy with both arms low for twait1+1 cycles when `bit_tick` is held high. The delays and window are latched at the start, so later changes on those inputs have no effect.
- R3: Delay and window counts advance only in cycles where `bit_tick` is high. With `bit_tick` low, the block stays in its current wait indefinitely.
- R4: Each acknowledge search holds `ack_arm` high for at most search_len+1 cycles. If no acknowledge or reject is seen in that time, the block ends with `status` = 3 (timeout).
- R5: For a write (`is_pin` = 0), an acknowledge in the first search leads to a second wait of twait2+1 cycles and then a second search. An acknowledge in that second search ends with `status` = 1 (success).
- R6: A reject (`nak_seen` high while `ack_arm` is high) in either search ends the sequence on the next cycle with `status` = 2 (fail). No later wait or search follows.
- R7: For a PIN command (`is_pin` = 1), an acknowledge in the first search leads to a wait of twait2+1 cycles. Then `hdr_arm` pulses high for exactly one cycle, then the block ends with `status` = 1, and no second search is run.
- R8: While busy, `status` reads 0. Once done, `done` and `status` hold until the next start, and a start from the done state begins a new sequence.
- R9: A start pulse while the block is busy is ignored and the running sequence continues unchanged.
- R10: When `ack_seen` and `nak_seen` are both high in one search cycle, the reject wins and the result is fail (default variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period; counts advance on it |
| start | input | 1 | Begin a sequence (taken only when idle or done) |
| is_pin | input | 1 | 1 = PIN command flow, 0 = data write flow |
| twait1 | input | CNT_W | First delay in bit periods |
| twait2 | input | CNT_W | Second delay in bit periods |
| search_len | input | CNT_W | Acknowledge search window in bit periods |
| ack_seen | input | 1 | Acknowledge pattern found by the matcher |
| nak_seen | input | 1 | Matcher saw a reply that is not an acknowledge |
| ack_arm | output | 1 | Enables the acknowledge matcher during a search |
| hdr_arm | output | 1 | One-cycle arm strobe to the header detector |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; status valid |
| status | output | 2 | 0 none, 1 success, 2 fail, 3 timeout |

## Verification
The bench sweeps every combination of small delays and windows for both command kinds. It places the acknowledge on the first cycle of a search, on the last cycle, and one cycle too late. An off-by-one in the counter would show up as a wait or search one cycle too long or short, or as a last-cycle acknowledge being reported as a timeout. Reject and acknowledge-plus-reject replies catch a design that carries on to a second search after a failure. A held-low tick catches a counter that runs on the system clock. A start pulse in the middle of a search catches a design that restarts while busy, and the hold check catches a status that decays before the next start.

// File: rtl/ack_wait_seq_pkg.sv
package ack_wait_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_WAIT1, S_CHECK1, S_WAIT2, S_CHECK2, S_ARM_HDR, S_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      RES_NONE = 2'd0,
      RES_OK   = 2'd1,
      RES_FAIL = 2'd2,
      RES_TMO  = 2'd3
   } seq_result_t;
endpackage

// File: rtl/ack_wait_seq_cnt.sv
module ack_wait_seq_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/ack_wait_seq_resolve.sv
module ack_wait_seq_resolve #(
   parameter bit NAK_WINS = 1'b1
) (
   input  logic ack_in,
   input  logic nak_in,
   output logic hit,
   output logic miss
);
   generate
      if (NAK_WINS) begin : g_nak_first
         assign miss = nak_in;
         assign hit  = ack_in & ~nak_in;
      end else begin : g_ack_first
         assign hit  = ack_in;
         assign miss = nak_in & ~ack_in;
      end
   endgenerate
endmodule

// File: rtl/ack_wait_seq_ctrl.sv
module ack_wait_seq_ctrl
   import ack_wait_seq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_pin,
   input  logic [CNT_W-1:0] twait1,
   input  logic [CNT_W-1:0] twait2,
   input  logic [CNT_W-1:0] search_len,
   input  logic             hit,
   input  logic             miss,
   input  logic             cnt_zero,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output seq_state_t       state,
   output seq_result_t      result
);
   seq_state_t       state_q, state_d;
   seq_result_t      res_q, res_d;
   logic             pin_q;
   logic [CNT_W-1:0] d2_q, win_q;
   logic             take;

   assign take = start && ((state_q == S_IDLE) || (state_q == S_DONE));

   always_comb begin
      state_d  = state_q;
      res_d    = res_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      case (state_q)
         S_IDLE, S_DONE: begin
            if (start) begin
               state_d  = S_WAIT1;
               res_d    = RES_NONE;
               cnt_load = 1'b1;
               cnt_val  = twait1;
            end
         end
         S_WAIT1: begin
            if (cnt_zero) begin
               state_d  = S_CHECK1;
               cnt_load = 1'b1;
               cnt_val  = win_q;
            end
         end
         S_CHECK1, S_CHECK2: begin
            if (miss) begin
               state_d = S_DONE;
               res_d   = RES_FAIL;
            end else if (hit) begin
               if (state_q == S_CHECK1) begin
                  state_d  = S_WAIT2;
                  cnt_load = 1'b1;
                  cnt_val  = d2_q;
               end else begin
                  state_d = S_DONE;
                  res_d   = RES_OK;
               end
            end else if (cnt_zero) begin
               state_d = S_DONE;
               res_d   = RES_TMO;
            end
         end
         S_WAIT2: begin
            if (cnt_zero) begin
               if (pin_q) begin
                  state_d = S_ARM_HDR;
               end else begin
                  state_d  = S_CHECK2;
                  cnt_load = 1'b1;
                  cnt_val  = win_q;
               end
            end
         end
         S_ARM_HDR: begin
            state_d = S_DONE;
            res_d   = RES_OK;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         res_q   <= RES_NONE;
         pin_q   <= 1'b0;
         d2_q    <= '0;
         win_q   <= '0;
      end else begin
         state_q <= state_d;
         res_q   <= res_d;
         if (take) begin
            pin_q <= is_pin;
            d2_q  <= twait2;
            win_q <= search_len;
         end
      end
   end

   assign state  = state_q;
   assign result = res_q;
endmodule

// File: rtl/ack_wait_seq.sv
module ack_wait_seq
   import ack_wait_seq_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit NAK_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             start,
   input  logic             is_pin,
   input  logic [CNT_W-1:0] twait1,
   input  logic [CNT_W-1:0] twait2,
   input  logic [CNT_W-1:0] search_len,
   input  logic             ack_seen,
   input  logic             nak_seen,
   output logic             ack_arm,
   output logic             hdr_arm,
   output logic             busy,
   output logic             done,
   output logic [1:0]       status
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ack_wait_seq: CNT_W must be at least 2");
      end
   endgenerate

   logic             hit, miss, cnt_zero, cnt_load;
   logic [CNT_W-1:0] cnt_val;
   seq_state_t       state;
   seq_result_t      result;

   ack_wait_seq_resolve #(.NAK_WINS(NAK_WINS)) u_resolve (
      .ack_in (ack_seen),
      .nak_in (nak_seen),
      .hit    (hit),
      .miss   (miss)
   );

   ack_wait_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .tick     (bit_tick),
      .zero     (cnt_zero)
   );

   ack_wait_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_pin     (is_pin),
      .twait1     (twait1),
      .twait2     (twait2),
      .search_len (search_len),
      .hit        (hit),
      .miss       (miss),
      .cnt_zero   (cnt_zero),
      .cnt_load   (cnt_load),
      .cnt_val    (cnt_val),
      .state      (state),
      .result     (result)
   );

   assign ack_arm = (state == S_CHECK1) || (state == S_CHECK2);
   assign hdr_arm = (state == S_ARM_HDR);
   assign done    = (state == S_DONE);
   assign busy    = (state != S_IDLE) && (state != S_DONE);
   assign status  = result;
endmodule

// File: rtl/ack_wait_seq_chk.sv
module ack_wait_seq_chk #(
   parameter bit NAK_WINS = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       ack_seen,
   input logic       nak_seen,
   input logic       ack_arm,
   input logic       hdr_arm,
   input logic       busy,
   input logic       done,
   input logic [1:0] status
);
   // R7
   arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_arm && hdr_arm));

   // R7
   hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_arm |=> (!hdr_arm && done && status == 2'd1));

   // R6
   reject_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_arm && nak_seen && (NAK_WINS || !ack_seen)) |=> (done && status == 2'd2));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(status)));

   // R8
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status == 2'd0 && !done));

   // R4
   timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && status == 2'd3) |-> $past(ack_arm));
endmodule

bind ack_wait_seq ack_wait_seq_chk #(.NAK_WINS(NAK_WINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ack_seen (ack_seen),
   .nak_seen (nak_seen),
   .ack_arm  (ack_arm),
   .hdr_arm  (hdr_arm),
   .busy     (busy),
   .done     (done),
   .status   (status)
);

// File: tb/ack_wait_seq_test.sv
module ack_wait_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bit_tick = 1'b1;
   logic         start = 1'b0;
   logic         is_pin = 1'b0;
   logic [W-1:0] twait1 = '0, twait2 = '0, search_len = '0;
   logic         ack_seen = 1'b0, nak_seen = 1'b0;
   logic         ack_arm, hdr_arm, busy, done;
   logic [1:0]   status;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ack_wait_seq #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
      .is_pin(is_pin), .twait1(twait1), .twait2(twait2),
      .search_len(search_len), .ack_seen(ack_seen), .nak_seen(nak_seen),
      .ack_arm(ack_arm), .hdr_arm(hdr_arm), .busy(busy), .done(done),
      .status(status)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         summary();
      end
   end

   // rk: reply kind per check, 0 ack, 1 reject, 2 both; rN: arm cycle to reply on (0 = never)
   task automatic run_txn(input bit pin, input int d1, input int d2, input int w,
                          input int r1, input int k1, input int r2, input int k2);
      int w1 = 0, a1 = 0, w2 = 0, a2 = 0, h = 0, idx = 0, ac = 0, g = 0;
      bit prev = 0;
      int ew2 = 0, ea1, ea2 = 0, eh = 0, est;
      is_pin = pin; twait1 = W'(d1); twait2 = W'(d2); search_len = W'(w);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      twait1 = 16'd9; twait2 = 16'd9; search_len = 16'd9; is_pin = ~pin;
      while (!done && g < 400) begin
         ack_seen = 1'b0; nak_seen = 1'b0;
         if (ack_arm) begin
            if (!prev) begin idx++; ac = 0; end
            ac++;
            if (idx == 1) a1++; else a2++;
            if (ac == ((idx == 1) ? r1 : r2)) begin
               int k = (idx == 1) ? k1 : k2;
               ack_seen = (k != 1);
               nak_seen = (k != 0);
            end
         end else if (hdr_arm) h++;
         else if (busy) begin
            if (idx == 0) w1++; else w2++;
         end
         prev = ack_arm;
         @(negedge clk);
         g++;
      end
      ack_seen = 1'b0; nak_seen = 1'b0;
      // expected values from the requirements
      if (r1 == 0 || r1 > w + 1) begin
         ea1 = w + 1; est = 3;
      end else begin
         ea1 = r1;
         if (k1 != 0) est = 2;
         else begin
            ew2 = d2 + 1;
            if (pin) begin eh = 1; est = 1; end
            else if (r2 == 0 || r2 > w + 1) begin ea2 = w + 1; est = 3; end
            else begin ea2 = r2; est = (k2 != 0) ? 2 : 1; end
         end
      end
      chk("R2 first wait", w1, d1 + 1);
      chk("R4 first search length", a1, ea1);
      chk("R5 second wait", w2, ew2);
      chk("R5 second search length", a2, ea2);
      chk("R7 header arm pulses", h, eh);
      chk("R4 R5 R6 R7 status", int'(status), est);
      chk("R8 done after sequence", int'(done), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 ack_arm", int'(ack_arm), 0);
      chk("R1 hdr_arm", int'(hdr_arm), 0);
      chk("R1 status", int'(status), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R5 R7 sweep with acknowledge replies
      for (int p = 0; p < 2; p++)
         for (int d1 = 0; d1 < 3; d1++)
            for (int d2 = 0; d2 < 3; d2++)
               for (int w = 0; w < 3; w++)
                  for (int i = 0; i < 4; i++) begin
                     int ra = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? w + 1 : w + 2;
                     int rb = (i == 3) ? 1 : (i == 0) ? w + 1 : (i == 1) ? w + 2 : 1;
                     run_txn(p[0], d1, d2, w, ra, 0, rb, 0);
                  end

      // R6 reject in each search, R10 both at once
      for (int w = 0; w < 3; w++) begin
         run_txn(1'b0, 1, 1, w, w + 1, 1, 1, 0);
         run_txn(1'b0, 1, 1, w, 1, 0, w + 1, 1);
         run_txn(1'b1, 0, 2, w, 1, 1, 0, 0);
         run_txn(1'b0, 2, 0, w, 1, 2, 1, 0);
         run_txn(1'b0, 0, 1, w, 1, 0, 1, 2);
      end

      // R8 result held, status cleared on new start
      repeat (5) @(negedge clk);
      chk("R8 done held", int'(done), 1);
      chk("R8 status held", int'(status), 2);
      is_pin = 1'b0; twait1 = 16'd1; twait2 = 16'd0; search_len = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 status cleared while busy", int'(status), 0);
      chk("R8 busy after restart", int'(busy), 1);
      while (!done) @(negedge clk);

      // R3 no tick, no progress
      bit_tick = 1'b0;
      twait1 = 16'd2; search_len = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      chk("R3 stalled without tick arm", int'(ack_arm), 0);
      chk("R3 stalled without tick busy", int'(busy), 1);
      bit_tick = 1'b1;
      begin
         int n = 0;
         while (!ack_arm && n < 50) begin @(negedge clk); n++; end
         chk("R3 cycles to search once ticking", n, 3);
      end
      while (!done) @(negedge clk);
      chk("R3 timeout status", int'(status), 3);

      // R9 start while busy ignored
      is_pin = 1'b0; twait1 = 16'd0; twait2 = 16'd0; search_len = 16'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!ack_arm) @(negedge clk);
      start = 1'b1; is_pin = 1'b1; twait1 = 16'd7; search_len = 16'd0;
      begin
         int n = 0;
         while (ack_arm && n < 50) begin
            n++;
            @(negedge clk);
            start = 1'b0;
         end
         chk("R9 search unaffected by start", n, 4);
      end
      chk("R9 status timeout", int'(status), 3);
      chk("R9 done", int'(done), 1);

      summary();
   end
endmodule